// File: doc/BRIEF.md
# E1 Single-Channel Loopback with Idle Fill

This block sits between a system-side framer and a line-side framer on a 32-timeslot E1 path. Both byte streams come in with a strobe and a 5-bit timeslot number. Software picks one timeslot and switches the loop on through a small control register. The system's outgoing byte for that timeslot is then sent back to the system on the receive stream, at the same timeslot position one frame later. The line never sees that byte: the timeslot it would have occupied carries a programmable idle code. Every other timeslot passes through both directions untouched.

Configuration changes are held in a pending copy. They take effect together at the next transmit frame boundary, which is the strobe with timeslot 0. This keeps a timeslot from being only partly looped. Both outputs are registered, so each output byte follows its input strobe by one clock. The capture buffer is marked empty whenever the active selection changes. Bytes captured under an old setting are therefore never inserted.

Top module: `e1_slot_loopback`

## Requirements
- R1: The control register (selected when `cfg_sel`=0) holds the loop enable at bit 7 and the timeslot address at bits 4:0, and resets to 0x00. Bits 6:5 read back as 0 whatever was written, so writing 0xE3 reads back 0x83.
- R2: The idle-code register (selected when `cfg_sel`=1) resets to 0xFF. A write updates it and its readback from the next clock on.
- R3: With the loop disabled, `line_data` equals the `tx_data` byte and `sys_data` equals the `rx_data` byte of the previous clock, in every timeslot.
- R4: With the loop active, the line-side byte in the selected timeslot is the current idle code, and all other line timeslots carry `tx_data` unchanged.
- R5: With the loop active, the system-side byte in the selected timeslot is the `tx_data` byte of that timeslot from the previous frame. In the first frame after the selection becomes active, it carries `rx_data` instead.
- R6: A control write becomes active only at the next transmit strobe with timeslot 0. A write in the middle of a frame leaves the rest of that frame under the old setting.
- R7: Any address from 0 to 31 can be looped, including the first timeslot (0) and the last (31).
- R8: `line_valid` and `sys_valid` repeat `tx_valid` and `rx_valid` one clock later, and are low after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 idle code |
| cfg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register readback (pending value) |
| idle_rdata | output | 8 | Idle-code register readback |
| tx_valid | input | 1 | Strobe for the system-to-line byte |
| tx_slot | input | 5 | Timeslot of the system-to-line byte |
| tx_data | input | 8 | System-to-line byte |
| line_valid | output | 1 | Strobe for the byte toward the line |
| line_data | output | 8 | Byte toward the line |
| rx_valid | input | 1 | Strobe for the line-to-system byte |
| rx_slot | input | 5 | Timeslot of the line-to-system byte |
| rx_data | input | 8 | Line-to-system byte |
| sys_valid | output | 1 | Strobe for the byte toward the system |
| sys_data | output | 8 | Byte toward the system |

## Verification
Each output byte is due one clock after the edge that takes in its strobe. The bench therefore drives every timeslot on a falling edge, waits for the next rising edge, and samples 1 ns later. The looped byte is due one frame (32 strobes) after it was captured. The bench checks it against its own formula for the previous frame's data. A configuration write becomes visible on the data path only from the next timeslot-0 strobe. The bench keeps the written value pending in its own model until the next frame starts, and checks the remaining timeslots of the current frame against the old setting.

// File: rtl/e1lb_pkg.sv
package e1lb_pkg;
  localparam int NUM_SLOTS = 32;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int BYTE_W    = 8;
  localparam int EN_BIT    = 7;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } lb_cfg_t;

  function automatic lb_cfg_t ctrl_decode(input logic [BYTE_W-1:0] w);
    lb_cfg_t c;
    c.en   = w[EN_BIT];
    c.slot = w[SLOT_W-1:0];
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_encode(input lb_cfg_t c);
    logic [BYTE_W-1:0] w;
    w              = '0;
    w[EN_BIT]      = c.en;
    w[SLOT_W-1:0]  = c.slot;
    return w;
  endfunction

  function automatic logic slot_hit(input logic v, input logic [SLOT_W-1:0] s,
                                    input lb_cfg_t c);
    return v && c.en && (s == c.slot);
  endfunction
endpackage

// File: rtl/e1lb_cfg.sv
module e1lb_cfg
  import e1lb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              tx_valid,
  input  logic [SLOT_W-1:0] tx_slot,
  output lb_cfg_t           eff_cfg,
  output logic              cfg_changed,
  output logic [BYTE_W-1:0] idle_code,
  output logic [BYTE_W-1:0] ctrl_rdata
);
  lb_cfg_t pend_q, act_q;
  logic    boundary;

  assign boundary    = tx_valid && (tx_slot == '0);
  assign cfg_changed = boundary && (pend_q != act_q);
  assign eff_cfg     = boundary ? pend_q : act_q;
  assign ctrl_rdata  = ctrl_encode(pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      act_q     <= '0;
      idle_code <= IDLE_RESET;
    end else begin
      if (cfg_we && !cfg_sel) pend_q    <= ctrl_decode(cfg_wdata);
      if (cfg_we && cfg_sel)  idle_code <= cfg_wdata;
      if (boundary)           act_q     <= pend_q;
    end
  end

  p_hold_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> (act_q == $past(act_q)));
endmodule

// File: rtl/e1lb_line_path.sv
module e1lb_line_path
  import e1lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lb_cfg_t           eff_cfg,
  input  logic              cfg_changed,
  input  logic [BYTE_W-1:0] idle_code,
  input  logic              tx_valid,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              line_valid,
  output logic [BYTE_W-1:0] line_data,
  output logic [BYTE_W-1:0] loop_byte,
  output logic              loop_ok
);
  logic line_hit;

  assign line_hit = slot_hit(tx_valid, tx_slot, eff_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid <= 1'b0;
      line_data  <= '0;
      loop_byte  <= '0;
      loop_ok    <= 1'b0;
    end else begin
      line_valid <= tx_valid;
      if (tx_valid) line_data <= line_hit ? idle_code : tx_data;
      if (line_hit) begin
        loop_byte <= tx_data;
        loop_ok   <= 1'b1;
      end else if (cfg_changed) begin
        loop_ok   <= 1'b0;
      end
    end
  end

  p_line_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> (line_data == $past(idle_code)));
  p_line_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !line_hit) |=> (line_data == $past(tx_data)));
  p_stale_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_changed && !line_hit) |=> !loop_ok);
  p_line_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> !line_valid);
endmodule

// File: rtl/e1lb_sys_path.sv
module e1lb_sys_path
  import e1lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lb_cfg_t           eff_cfg,
  input  logic              cfg_changed,
  input  logic [BYTE_W-1:0] loop_byte,
  input  logic              loop_ok,
  input  logic              rx_valid,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              sys_valid,
  output logic [BYTE_W-1:0] sys_data
);
  logic sys_ins;

  assign sys_ins = slot_hit(rx_valid, rx_slot, eff_cfg) && loop_ok && !cfg_changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_valid <= 1'b0;
      sys_data  <= '0;
    end else begin
      sys_valid <= rx_valid;
      if (rx_valid) sys_data <= sys_ins ? loop_byte : rx_data;
    end
  end

  p_sys_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !sys_ins) |=> (sys_data == $past(rx_data)));
  p_sys_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ins |=> (sys_data == $past(loop_byte)));
endmodule

// File: rtl/e1_slot_loopback.sv
module e1_slot_loopback
  import e1lb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] ctrl_rdata,
  output logic [BYTE_W-1:0] idle_rdata,
  input  logic              tx_valid,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              line_valid,
  output logic [BYTE_W-1:0] line_data,
  input  logic              rx_valid,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              sys_valid,
  output logic [BYTE_W-1:0] sys_data
);
  lb_cfg_t           eff_cfg;
  logic              cfg_changed;
  logic [BYTE_W-1:0] idle_code;
  logic [BYTE_W-1:0] loop_byte;
  logic              loop_ok;

  assign idle_rdata = idle_code;

  e1lb_cfg #(.IDLE_RESET(IDLE_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tx_valid(tx_valid), .tx_slot(tx_slot),
    .eff_cfg(eff_cfg), .cfg_changed(cfg_changed), .idle_code(idle_code),
    .ctrl_rdata(ctrl_rdata)
  );

  e1lb_line_path u_line (
    .clk(clk), .rst_n(rst_n), .eff_cfg(eff_cfg), .cfg_changed(cfg_changed),
    .idle_code(idle_code), .tx_valid(tx_valid), .tx_slot(tx_slot),
    .tx_data(tx_data), .line_valid(line_valid), .line_data(line_data),
    .loop_byte(loop_byte), .loop_ok(loop_ok)
  );

  e1lb_sys_path u_sys (
    .clk(clk), .rst_n(rst_n), .eff_cfg(eff_cfg), .cfg_changed(cfg_changed),
    .loop_byte(loop_byte), .loop_ok(loop_ok), .rx_valid(rx_valid),
    .rx_slot(rx_slot), .rx_data(rx_data), .sys_valid(sys_valid),
    .sys_data(sys_data)
  );

  p_rst_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !sys_valid);
endmodule

// File: tb/e1_slot_loopback_test.sv
`timescale 1ns/1ps
module e1_slot_loopback_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] ctrl_rdata, idle_rdata;
  logic       tx_valid = 1'b0, rx_valid = 1'b0;
  logic [4:0] tx_slot = '0, rx_slot = '0;
  logic [7:0] tx_data = '0, rx_data = '0;
  logic       line_valid, sys_valid;
  logic [7:0] line_data, sys_data;

  int n_run = 0, n_fail = 0;
  int f_cnt = 0;
  logic       m_pend_en = 0, m_en = 0;
  logic [4:0] m_pend_slot = 0, m_slot = 0;
  logic [7:0] m_idle = 8'hFF;
  int         m_start = 0;

  always #4 clk = ~clk;

  e1_slot_loopback uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .idle_rdata(idle_rdata),
    .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_data(tx_data),
    .line_valid(line_valid), .line_data(line_data),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data),
    .sys_valid(sys_valid), .sys_data(sys_data)
  );

  function automatic logic [7:0] txb(input int f, input int s);
    return 8'((f * 37 + s * 5 + 1) & 255);
  endfunction
  function automatic logic [7:0] rxb(input int f, input int s);
    return 8'(((f * 11) ^ (s * 7) ^ 165) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tx_valid = 1'b0; rx_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8", "line_valid idle", int'(line_valid), 0);
    chk("R8", "sys_valid idle", int'(sys_valid), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_idle = val;
    else begin m_pend_en = val[7]; m_pend_slot = val[4:0]; end
  endtask

  task automatic run_frame(input bit do_wr, input int wr_slot, input logic [7:0] wr_val);
    logic [7:0] el, es;
    if ({m_pend_en, m_pend_slot} != {m_en, m_slot}) begin
      m_en = m_pend_en; m_slot = m_pend_slot; m_start = f_cnt;
    end
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      tx_valid = 1'b1; rx_valid = 1'b1;
      tx_slot = 5'(s); rx_slot = 5'(s);
      tx_data = txb(f_cnt, s); rx_data = rxb(f_cnt, s);
      cfg_we = do_wr && (s == wr_slot);
      cfg_sel = 1'b0; cfg_wdata = wr_val;
      @(posedge clk); #1;
      el = (m_en && s == int'(m_slot)) ? m_idle : txb(f_cnt, s);
      es = (m_en && s == int'(m_slot) && f_cnt > m_start) ? txb(f_cnt - 1, s) : rxb(f_cnt, s);
      chk((m_en && s == int'(m_slot)) ? "R4" : "R3", $sformatf("line f%0d s%0d", f_cnt, s),
          int'(line_data), int'(el));
      chk((m_en && s == int'(m_slot)) ? "R5" : "R3", $sformatf("sys f%0d s%0d", f_cnt, s),
          int'(sys_data), int'(es));
      chk("R8", "line_valid", int'(line_valid), 1);
      chk("R8", "sys_valid", int'(sys_valid), 1);
      if (do_wr && s == wr_slot) begin
        m_pend_en = wr_val[7]; m_pend_slot = wr_val[4:0];
      end
    end
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0; cfg_we = 1'b0;
    f_cnt++;
  endtask

  task automatic t_reset;
    chk("R1", "ctrl reset", int'(ctrl_rdata), 8'h00);
    chk("R2", "idle reset", int'(idle_rdata), 8'hFF);
    chk("R8", "line_valid reset", int'(line_valid), 0);
    chk("R8", "sys_valid reset", int'(sys_valid), 0);
  endtask

  task automatic t_passthrough;
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
  endtask

  task automatic t_loop_basic;
    cfg_write(1'b0, 8'h87);
    chk("R1", "ctrl readback", int'(ctrl_rdata), 8'h87);
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
  endtask

  task automatic t_idle_change;
    cfg_write(1'b1, 8'h5A);
    chk("R2", "idle readback", int'(idle_rdata), 8'h5A);
    run_frame(0, 0, 8'h00);
  endtask

  task automatic t_reserved_bits;
    cfg_write(1'b0, 8'hE0 | 8'd31);
    chk("R1", "bits 6:5 ignored", int'(ctrl_rdata), 8'h9F);
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
  endtask

  task automatic t_mid_frame;
    run_frame(1, 10, 8'h94);
    chk("R6", "pending readback", int'(ctrl_rdata), 8'h94);
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
  endtask

  task automatic t_slot_zero;
    cfg_write(1'b0, 8'h80);
    run_frame(0, 0, 8'h00);
    run_frame(0, 0, 8'h00);
    chk("R7", "slot 0 readback", int'(ctrl_rdata), 8'h80);
  endtask

  task automatic t_disable;
    cfg_write(1'b0, 8'h00);
    run_frame(0, 0, 8'h00);
    chk("R3", "disabled readback", int'(ctrl_rdata), 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_passthrough();
    t_loop_basic();
    t_idle_change();
    t_reserved_bits();
    t_mid_frame();
    t_slot_zero();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule